// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a 24-bit down-counter that produces a regular tick for an operating system scheduler or any periodic job. Software programs a reload value, picks a count source and sets the run bit. The counter then starts from the reload value and steps down by one on every count event. A count event is either every cycle of the block clock or each cycle in which the external reference strobe is high. The step taken when the counter already holds zero is the expiry. It sets a sticky status flag. If the interrupt enable is set, it also raises a one-cycle request pulse. The counter then starts again from the reload value, or stops when the reload value is zero.

Software reaches four word registers through a single-cycle read/write port. The port has no valid/ready handshake and never applies back-pressure: an access is taken in every cycle in which `bus_en` is high. Read data is combinational from the current state. Read side effects take place at the clock edge that closes the access. Register writes take priority over events the counter produces in the same cycle. A control write that keeps the run bit at 1 therefore wins over the automatic stop at a zero-reload expiry. A write that forces a reload, or that clears the run bit, suppresses the count step in that cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value registers read 0 and `tick_irq` is low.
- R2: The control/status register is at index 0. Bit 0 is run, bit 1 is interrupt enable, bit 2 is the source select (1 = every clock, 0 = cycles with `ref_stb` high) and bit 16 is the sticky expiry flag. A write updates only bits 2:0. All other read bits are 0.
- R3: A read of index 0 returns the state before the access and then clears the expiry flag. An expiry in the same cycle leaves the flag set.
- R4: While running, the value at index 2 steps down by one per count event. An expiry happens once every reload+1 count events. Setting run from 0 to 1 first loads the reload value.
- R5: With source select 0, the counter changes only in cycles where `ref_stb` is high.
- R6: Every expiry sets the flag. `tick_irq` is high for exactly one cycle, the cycle after the expiry step, and only if interrupt enable was 1.
- R7: An expiry with a reload value of 0 clears the run bit, unless a control write in the same cycle sets it.
- R8: Any write to index 2, whatever its data, loads the reload value into the counter and clears the expiry flag.
- R9: Index 2 reads 0 while the run bit is 0.
- R10: Index 3 always reads 10000 and ignores writes.
- R11: A control write that changes the source select while run stays 1 loads the reload value into the counter.
- R12: The reload register (index 1) and the counter hold 24 bits. Read bits 31:24 are 0 and written bits 31:24 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 2 | Word register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| ref_stb | input | 1 | External reference count strobe |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The counter, reload, run and flag state all appear at the register port. A wrong count or a missed reload shows on the very next read of index 2. A misplaced expiry shows in the expiry flag and in the `tick_irq` pulse in the cycle right after the bad step. Flag clear and set ordering errors show on the second of two back-to-back reads of index 0. The bench runs a cycle-accurate model next to the design and compares every read and every cycle of `tick_irq`, so any divergence is reported within one cycle of its first visible effect.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    IDX_CTRL    = 2'd0,
    IDX_RELOAD  = 2'd1,
    IDX_CURRENT = 2'd2,
    IDX_CALIB   = 2'd3
  } reg_idx_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_IE_BIT   = 1;
  localparam int CTL_SRC_BIT  = 2;
  localparam int CTL_FLAG_BIT = 16;

  typedef struct packed {
    logic src;
    logic ie;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic ctrl_wr;
    logic reload_wr;
    logic cur_wr;
    logic ctrl_rd;
  } bus_ops_t;

endpackage

// File: rtl/tick_bus_if.sv
module tick_bus_if
  import tick_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 24,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_idx,
  input  ctrl_t             ctrl,
  input  logic              flag,
  input  logic [CNT_W-1:0]  reload,
  input  logic [CNT_W-1:0]  count,
  output bus_ops_t          ops,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - CNT_W;

  reg_idx_e idx;
  assign idx = reg_idx_e'(bus_idx);

  always_comb begin
    ops.ctrl_wr   = bus_en &&  bus_we && (idx == IDX_CTRL);
    ops.reload_wr = bus_en &&  bus_we && (idx == IDX_RELOAD);
    ops.cur_wr    = bus_en &&  bus_we && (idx == IDX_CURRENT);
    ops.ctrl_rd   = bus_en && !bus_we && (idx == IDX_CTRL);
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_CTRL: begin
        rdata[CTL_RUN_BIT]  = ctrl.run;
        rdata[CTL_IE_BIT]   = ctrl.ie;
        rdata[CTL_SRC_BIT]  = ctrl.src;
        rdata[CTL_FLAG_BIT] = flag;
      end
      IDX_RELOAD:  rdata = {{PAD_W{1'b0}}, reload};
      IDX_CURRENT: rdata = ctrl.run ? {{PAD_W{1'b0}}, count} : '0;
      IDX_CALIB:   rdata = DATA_W'(CAL_VALUE);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
  import tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ops_t          ops,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic [CNT_W-1:0]  reload,
  output logic              load_req,
  output logic              stop_wr
);
  ctrl_t wr_ctrl;
  assign wr_ctrl = ctrl_t'(wdata[2:0]);

  always_comb begin
    load_req = ops.cur_wr ||
               (ops.ctrl_wr && wr_ctrl.run &&
                (!ctrl.run || (wr_ctrl.src != ctrl.src)));
    stop_wr  = ops.ctrl_wr && !wr_ctrl.run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      flag   <= 1'b0;
      reload <= '0;
    end else begin
      if (ops.ctrl_wr) begin
        ctrl <= wr_ctrl;
      end else if (expire && (reload == '0)) begin
        ctrl.run <= 1'b0;
      end
      if (expire) begin
        flag <= 1'b1;
      end else if (ops.ctrl_rd || ops.cur_wr) begin
        flag <= 1'b0;
      end
      if (ops.reload_wr) begin
        reload <= wdata[CNT_W-1:0];
      end
    end
  end

  // R7
  zero_reload_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (reload == '0) && !ops.ctrl_wr) |=> !ctrl.run);
  // R8
  cur_write_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ops.cur_wr |=> !flag);
  // R3
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ops.ctrl_rd && !expire) |=> !flag);
  // R6
  expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  // R2
  ctrl_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ops.ctrl_wr |=> (ctrl == $past(wdata[2:0])));
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] reload,
  input  logic             load_req,
  input  logic             stop_wr,
  input  logic             ref_stb,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             irq
);
  logic src_evt;
  logic step;

  always_comb begin
    src_evt = ctrl.src ? 1'b1 : ref_stb;
    step    = ctrl.run && src_evt && !load_req && !stop_wr;
    expire  = step && (count == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= expire && ctrl.ie;
      if (load_req) begin
        count <= reload;
      end else if (step) begin
        count <= (count == '0) ? reload : count - 1'b1;
      end
    end
  end

  // R8
  forced_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (count == $past(reload)));
  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (count != '0)) |=> (count == CNT_W'($past(count) - 1'b1)));
  // R5
  idle_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.src && !ref_stb && !load_req) |=> $stable(count));
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(expire && ctrl.ie));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 24,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_stb,
  output logic              tick_irq
);
  bus_ops_t         ops;
  ctrl_t            ctrl;
  logic             flag;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             load_req;
  logic             stop_wr;
  logic             expire;

  tick_bus_if #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)
  ) u_bus (
    .bus_en(bus_en), .bus_we(bus_we), .bus_idx(bus_idx),
    .ctrl(ctrl), .flag(flag), .reload(reload), .count(count),
    .ops(ops), .rdata(bus_rdata)
  );

  tick_ctrl_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ops(ops), .wdata(bus_wdata),
    .expire(expire), .ctrl(ctrl), .flag(flag), .reload(reload),
    .load_req(load_req), .stop_wr(stop_wr)
  );

  tick_down_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .reload(reload),
    .load_req(load_req), .stop_wr(stop_wr), .ref_stb(ref_stb),
    .count(count), .expire(expire), .irq(tick_irq)
  );

  // R6
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> flag);
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_idx = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_stb = 1'b0;
  logic        tick_irq;

  int compared = 0;
  int mismatched = 0;

  logic        m_run, m_ie, m_src, m_flag, m_irq;
  logic [23:0] m_rl, m_cnt;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_stb(ref_stb), .tick_irq(tick_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [1:0] idx);
    case (idx)
      2'd0: exp_read = {15'd0, m_flag, 13'd0, m_src, m_ie, m_run};
      2'd1: exp_read = {8'd0, m_rl};
      2'd2: exp_read = m_run ? {8'd0, m_cnt} : 32'd0;
      default: exp_read = 32'd10000;
    endcase
  endfunction

  function automatic string idx_tag(input logic [1:0] idx);
    case (idx)
      2'd0: idx_tag = "R2";
      2'd1: idx_tag = "R12";
      2'd2: idx_tag = "R4";
      default: idx_tag = "R10";
    endcase
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] expv, input string tag);
    compared++;
    if (got !== expv) begin
      mismatched++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, expv, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0; m_rl = '0; m_cnt = '0;
  endtask

  task automatic cyc(input logic e, input logic w, input logic [1:0] idx,
                     input logic [31:0] wd, input logic stb, input string tag);
    logic cwr, cur, rdc, load, stopw, step, expd, n_run;
    @(negedge clk);
    bus_en = e; bus_we = w; bus_idx = idx; bus_wdata = wd; ref_stb = stb;
    #1;
    check({31'd0, tick_irq}, {31'd0, m_irq}, "R6");
    if (e && !w) check(bus_rdata, exp_read(idx), tag);
    cwr   = e && w && idx == 2'd0;
    cur   = e && w && idx == 2'd2;
    rdc   = e && !w && idx == 2'd0;
    load  = cur || (cwr && wd[0] && (!m_run || (wd[2] != m_src)));
    stopw = cwr && !wd[0];
    step  = m_run && (m_src || stb) && !load && !stopw;
    expd  = step && (m_cnt == '0);
    m_irq = expd && m_ie;
    if (expd) m_flag = 1;
    else if (rdc || cur) m_flag = 0;
    n_run = cwr ? wd[0] : ((expd && m_rl == '0) ? 1'b0 : m_run);
    if (load) m_cnt = m_rl;
    else if (step) m_cnt = (m_cnt == '0) ? m_rl : m_cnt - 1'b1;
    if (cwr) begin m_ie = wd[1]; m_src = wd[2]; end
    m_run = n_run;
    if (e && w && idx == 2'd1) m_rl = wd[23:0];
  endtask

  task automatic rd(input logic [1:0] idx, input string tag);
    cyc(1'b1, 1'b0, idx, 32'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    cyc(1'b1, 1'b1, idx, d, 1'b0, "WR");
  endtask

  task automatic idle(input int n, input logic stb);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 32'd0, stb, "IDLE");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
    // R10 calibration constant, write ignored
    rd(2'd3, "R10"); wr(2'd3, 32'h0000_0000); rd(2'd3, "R10");
    // R12 upper bits dropped
    wr(2'd1, 32'hAB00_0004); rd(2'd1, "R12");
    // R2 only low bits written
    wr(2'd0, 32'hFFFF_FFF8); rd(2'd0, "R2");
    wr(2'd0, 32'h0001_0003); rd(2'd0, "R2");
    // R5 reference strobe source
    idle(5, 1'b0); rd(2'd2, "R5");
    idle(2, 1'b1); rd(2'd2, "R5");
    // R11 source change reloads
    wr(2'd0, 32'h7); rd(2'd2, "R11");
    // R4 countdown and period, R6 pulse
    for (int i = 0; i < 14; i++) rd(2'd2, "R4");
    // R3 read clears flag
    rd(2'd0, "R3"); rd(2'd0, "R3");
    // R8 current write reloads and clears
    idle(3, 1'b0);
    wr(2'd2, 32'hDEAD_BEEF); rd(2'd0, "R8"); rd(2'd2, "R8");
    // R6 without interrupt enable
    wr(2'd0, 32'h5);
    for (int i = 0; i < 12; i++) rd(2'd2, "R6");
    // R7 zero reload stops
    wr(2'd1, 32'h0); wr(2'd2, 32'h1);
    idle(3, 1'b0); rd(2'd0, "R7");
    // R9 disabled current reads zero
    rd(2'd2, "R9");
    wr(2'd1, 32'h3); wr(2'd0, 32'h0); rd(2'd2, "R9");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [1:0]  ix;
      logic        stb;
      r   = $urandom_range(0, 99);
      ix  = 2'($urandom_range(0, 3));
      stb = ($urandom_range(0, 2) == 0);
      if (r < 55)      cyc(1'b0, 1'b0, 2'd0, 32'd0, stb, "IDLE");
      else if (r < 77) cyc(1'b1, 1'b0, ix, 32'd0, stb, idx_tag(ix));
      else if (r < 84) cyc(1'b1, 1'b1, 2'd1,
                           {8'($urandom), 21'd0, 3'($urandom_range(0, 6))}, stb, "WR");
      else if (r < 91) cyc(1'b1, 1'b1, 2'd0,
                           {29'($urandom), 2'($urandom), ($urandom_range(0, 3) != 0)}, stb, "WR");
      else if (r < 96) cyc(1'b1, 1'b1, 2'd2, $urandom, stb, "WR");
      else             cyc(1'b1, 1'b1, 2'd3, $urandom, stb, "WR");
    end
    idle(2, 1'b0);
    summary();
    $finish;
  end
endmodule